// File: doc/BRIEF.md
# Configurable PCM Serial Transmitter

This block takes decoded audio samples and sends them to a DAC over a three-wire serial link: a bit clock, a word clock that marks left or right, and a serial data line. The bit clock is made by dividing the system clock. Each frame has a left slot of 32 bit clocks followed by a right slot of 32 bit clocks. The audio word sits at the start of its slot, and the rest of the slot is filled with zeros.

Samples come in through a valid/ready handshake into a one-entry holding register. Each sample carries a left and a right value. At the start of every left slot the held pair moves into the shifter. If no pair is held at that point, the frame is sent as silence and an underrun flag is raised. Three settings are read only at the start of a left slot: word length (16, 18, 20 or 24 bits), bit order, and mono duplication. Stereo and dual-channel material use both input values. Mono material repeats the left value into the right slot.

Top module: `pcm_serial_tx`

## Requirements
- R1: `sck_o` is low after reset and toggles every `CLK_HALF` clock cycles, so one bit period is 2*`CLK_HALF` cycles.
- R2: Bit positions 0..31 of a frame form the left slot, with `ws_o` low. Positions 32..63 form the right slot, with `ws_o` high. `ws_o` changes only in the cycle in which `sck_o` falls.
- R3: `sd_o` changes only in the cycle in which `sck_o` falls, so it is stable at every rising edge of `sck_o`.
- R4: `cfg_width_i` selects the word length W: 0 gives 16, 1 gives 18, 2 gives 20 and 3 gives 24 bits. The word is sample bits [23 : 24-W]. It fills slot positions 0..W-1, and positions W..31 carry zero.
- R5: When `cfg_lsb_first_i` is 0, slot position 0 carries sample bit 23 and the bits run downward. When it is 1, slot position 0 carries sample bit 24-W and the bits run upward.
- R6: When `cfg_mono_i` is 1, the left sample is sent in both slots and `smp_right_i` has no effect.
- R7: `smp_ready_o` is high exactly when the holding register is empty. A pair is taken in a cycle where `smp_valid_i` and `smp_ready_o` are both high. The held pair is moved to the shifter at the next left-slot start, and `smp_ready_o` rises again in that cycle.
- R8: If no pair is held at a left-slot start, both slots of that frame carry only zeros and `underrun_o` stays high for the whole frame. `underrun_o` changes only at a left-slot start.
- R9: The three configuration inputs are sampled only at a left-slot start. Changing them during a frame does not alter that frame.
- R10: After reset, `sck_o`=0, `ws_o`=1, `sd_o`=0, `smp_ready_o`=1 and `underrun_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_width_i | input | 2 | Word length select (0:16, 1:18, 2:20, 3:24) |
| cfg_lsb_first_i | input | 1 | 1 = send the least significant bit first |
| cfg_mono_i | input | 1 | 1 = repeat the left sample into the right slot |
| smp_valid_i | input | 1 | A sample pair is offered |
| smp_ready_o | output | 1 | Holding register empty |
| smp_left_i | input | SMP_W | Left sample |
| smp_right_i | input | SMP_W | Right sample |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word clock (low = left, high = right) |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | The current frame is silence because no sample was held |

## Verification
The assertions check on every cycle the properties that hold at any time. The word clock, the data line and the underrun flag move only on a falling bit-clock edge or at a left-slot start. The ready flag stays up until a transfer takes place and drops right after one. What actually goes onto the wire can only be shown by the bench's scenarios. These cover the bit sequence for each word length in both bit orders, mono duplication with a right sample that differs from the left, silence frames after starvation, and a configuration change in the middle of a frame that must not touch that frame but must take hold in the next one.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  typedef enum logic [1:0] {
    WL_16 = 2'd0,
    WL_18 = 2'd1,
    WL_20 = 2'd2,
    WL_24 = 2'd3
  } wlen_e;

  function automatic int wlen_bits(wlen_e w);
    case (w)
      WL_16:   return 16;
      WL_18:   return 18;
      WL_20:   return 20;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/pcm_tx_clkgen.sv
module pcm_tx_clkgen #(
  parameter int CLK_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sck_o,
  output logic fall_o
);
  localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

  logic [CW-1:0] div_q;
  logic          sck_q;
  logic          wrap;

  assign wrap   = (div_q == CW'(CLK_HALF - 1));
  assign fall_o = wrap & sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (wrap) begin
      div_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_tx_holdbuf.sv
module pcm_tx_holdbuf #(
  parameter int SMP_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [SMP_W-1:0] left_i,
  input  logic [SMP_W-1:0] right_i,
  input  logic             pop_i,
  output logic             full_o,
  output logic [SMP_W-1:0] left_o,
  output logic [SMP_W-1:0] right_o
);
  logic             full_q;
  logic [SMP_W-1:0] left_q, right_q;

  assign ready_o = ~full_q;
  assign full_o  = full_q;
  assign left_o  = left_q;
  assign right_o = right_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else if (pop_i) begin
      full_q <= 1'b0;
    end else if (valid_i && !full_q) begin
      full_q  <= 1'b1;
      left_q  <= left_i;
      right_q <= right_i;
    end
  end
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
  import pcm_tx_pkg::*;
#(
  parameter int SMP_W  = 24,
  parameter int SLOT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             hold_full_i,
  input  logic [SMP_W-1:0] hold_left_i,
  input  logic [SMP_W-1:0] hold_right_i,
  input  wlen_e            cfg_width_i,
  input  logic             cfg_lsb_i,
  input  logic             cfg_mono_i,
  output logic             pop_o,
  output logic             ws_o,
  output logic             sd_o,
  output logic             underrun_o
);
  localparam int POS_W = $clog2(2 * SLOT_W);
  localparam int SIX_W = $clog2(SLOT_W);
  localparam int IDX_W = $clog2(SMP_W);

  logic [POS_W-1:0] pos_q, pos_nx;
  logic [SMP_W-1:0] left_q, right_q, left_c, right_c, word;
  wlen_e            wl_q, wl_c;
  logic             lsb_q, lsb_c;
  logic             ws_q, sd_q, und_q, bit_c, frame_start;
  logic [SIX_W-1:0] slot_pos;

  assign frame_start = fall_i && (pos_q == '1);
  assign pop_o       = frame_start && hold_full_i;
  assign pos_nx      = pos_q + 1'b1;
  assign slot_pos    = pos_nx[SIX_W-1:0];

  // New frame values are used from the first bit of the left slot
  always_comb begin
    left_c  = left_q;
    right_c = right_q;
    wl_c    = wl_q;
    lsb_c   = lsb_q;
    if (frame_start) begin
      wl_c  = cfg_width_i;
      lsb_c = cfg_lsb_i;
      if (hold_full_i) begin
        left_c  = hold_left_i;
        right_c = cfg_mono_i ? hold_left_i : hold_right_i;
      end else begin
        left_c  = '0;
        right_c = '0;
      end
    end
  end

  always_comb begin
    int nb, s;
    word  = pos_nx[POS_W-1] ? right_c : left_c;
    nb    = wlen_bits(wl_c);
    s     = int'(slot_pos);
    bit_c = 1'b0;
    if (s < nb)
      bit_c = word[IDX_W'(lsb_c ? (SMP_W - nb + s) : (SMP_W - 1 - s))];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '1;
      ws_q    <= 1'b1;
      sd_q    <= 1'b0;
      und_q   <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
      wl_q    <= WL_24;
      lsb_q   <= 1'b0;
    end else if (fall_i) begin
      pos_q   <= pos_nx;
      ws_q    <= pos_nx[POS_W-1];
      sd_q    <= bit_c;
      left_q  <= left_c;
      right_q <= right_c;
      wl_q    <= wl_c;
      lsb_q   <= lsb_c;
      if (frame_start) und_q <= ~hold_full_i;
    end
  end

  assign ws_o       = ws_q;
  assign sd_o       = sd_q;
  assign underrun_o = und_q;

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start |=> $stable(wl_q) && $stable(lsb_q));
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pcm_tx_pkg::*;
#(
  parameter int SMP_W    = 24,
  parameter int SLOT_W   = 32,
  parameter int CLK_HALF = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cfg_width_i,
  input  logic             cfg_lsb_first_i,
  input  logic             cfg_mono_i,
  input  logic             smp_valid_i,
  output logic             smp_ready_o,
  input  logic [SMP_W-1:0] smp_left_i,
  input  logic [SMP_W-1:0] smp_right_i,
  output logic             sck_o,
  output logic             ws_o,
  output logic             sd_o,
  output logic             underrun_o
);
  logic             fall, pop, hold_full;
  logic [SMP_W-1:0] hold_l, hold_r;

  pcm_tx_clkgen #(.CLK_HALF(CLK_HALF)) i_clkgen (
    .clk_i, .rst_ni, .sck_o, .fall_o(fall)
  );

  pcm_tx_holdbuf #(.SMP_W(SMP_W)) i_hold (
    .clk_i, .rst_ni,
    .valid_i (smp_valid_i),
    .ready_o (smp_ready_o),
    .left_i  (smp_left_i),
    .right_i (smp_right_i),
    .pop_i   (pop),
    .full_o  (hold_full),
    .left_o  (hold_l),
    .right_o (hold_r)
  );

  pcm_tx_serializer #(.SMP_W(SMP_W), .SLOT_W(SLOT_W)) i_ser (
    .clk_i, .rst_ni,
    .fall_i       (fall),
    .hold_full_i  (hold_full),
    .hold_left_i  (hold_l),
    .hold_right_i (hold_r),
    .cfg_width_i  (wlen_e'(cfg_width_i)),
    .cfg_lsb_i    (cfg_lsb_first_i),
    .cfg_mono_i   (cfg_mono_i),
    .pop_o        (pop),
    .ws_o, .sd_o, .underrun_o
  );

  // R2
  ws_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_o) |-> $fell(sck_o));
  // R3
  sd_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_o) |-> $fell(sck_o));
  // R8
  und_at_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(underrun_o) |-> $fell(ws_o));
  // R7
  ready_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ready_o && !smp_valid_i |=> smp_ready_o);
  // R7
  ready_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ready_o && smp_valid_i |=> !smp_ready_o);
endmodule

// File: tb/test_pcm_serial_tx.sv
module test_pcm_serial_tx;
  localparam int CLK_P = 10;
  localparam int HALF  = 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] width = 2'd3;
  logic lsb = 0, mono = 0, valid = 0;
  logic [23:0] s_l = '0, s_r = '0;
  logic ready, sck, ws, sd, und;

  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pcm_serial_tx #(.CLK_HALF(HALF)) i_pcm_serial_tx (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_width_i(width), .cfg_lsb_first_i(lsb), .cfg_mono_i(mono),
    .smp_valid_i(valid), .smp_ready_o(ready),
    .smp_left_i(s_l), .smp_right_i(s_r),
    .sck_o(sck), .ws_o(ws), .sd_o(sd), .underrun_o(und)
  );

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic int wbits(logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 18 : (c == 2'd2) ? 20 : 24;
  endfunction

  function automatic logic fbit(logic [23:0] l, logic [23:0] r, int w, logic lf, int pos);
    logic [23:0] wd;
    int s;
    wd = (pos < 32) ? l : r;
    s  = pos % 32;
    if (s >= w) return 1'b0;
    return lf ? wd[24 - w + s] : wd[23 - s];
  endfunction

  function automatic logic [63:0] frame(logic [23:0] l, logic [23:0] r, int w, logic lf);
    logic [63:0] f;
    for (int i = 0; i < 64; i++) f[i] = fbit(l, r, w, lf, i);
    return f;
  endfunction

  // Reference model, advanced at every rising clock edge
  int m_div, m_pos, m_w;
  logic m_sck, m_ws, m_sd, m_und, m_full, m_lsb;
  logic [23:0] m_l, m_r, m_hl, m_hr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_sck = 0; m_pos = 63; m_ws = 1; m_sd = 0; m_und = 0;
      m_full = 0; m_l = 0; m_r = 0; m_hl = 0; m_hr = 0; m_w = 24; m_lsb = 0;
    end else begin
      logic fall, push;
      fall = (m_div == HALF - 1) && m_sck;
      push = valid && !m_full;
      if (fall) begin
        if (m_pos == 63) begin
          if (m_full) begin
            m_l = m_hl; m_r = mono ? m_hl : m_hr; m_und = 0; m_full = 0;
          end else begin
            m_l = 0; m_r = 0; m_und = 1;
          end
          m_w = wbits(width); m_lsb = lsb;
        end
        m_pos = (m_pos + 1) % 64;
        m_ws  = (m_pos >= 32);
        m_sd  = fbit(m_l, m_r, m_w, m_lsb, m_pos);
      end
      if (push) begin m_full = 1; m_hl = s_l; m_hr = s_r; end
      if (m_div == HALF - 1) begin m_div = 0; m_sck = ~m_sck; end
      else m_div++;
    end
  end

  always @(negedge clk) if (rst_n) begin
    check("R1 sck_o vs model", 64'(sck), 64'(m_sck));
    check("R2 ws_o vs model", 64'(ws), 64'(m_ws));
    check("R3 sd_o vs model", 64'(sd), 64'(m_sd));
    check("R7 smp_ready_o vs model", 64'(ready), 64'(!m_full));
    check("R8 underrun_o vs model", 64'(und), 64'(m_und));
  end

  task automatic push(logic [23:0] l, logic [23:0] r);
    forever begin
      @(negedge clk);
      if (ready) break;
    end
    valid = 1; s_l = l; s_r = r;
    @(negedge clk);
    valid = 0;
    check("R7 ready low after transfer", 64'(ready), 64'd0);
  endtask

  // Captures the next frame; optional configuration change at bit chg_at
  task automatic grab(output logic [63:0] f, output logic u, input int chg_at,
                      input logic [1:0] nw, input logic nl, input logic nm);
    @(negedge ws);
    #1 u = und;
    for (int i = 0; i < 64; i++) begin
      @(posedge sck);
      #1 f[i] = sd;
      if (i == chg_at) begin width = nw; lsb = nl; mono = nm; end
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] f;
    logic u;
    logic [23:0] l, r;
    int t0, t1;

    repeat (3) @(negedge clk);
    // R10 reset values
    check("R10 sck", 64'(sck), 0);
    check("R10 ws", 64'(ws), 1);
    check("R10 sd", 64'(sd), 0);
    check("R10 ready", 64'(ready), 1);
    check("R10 underrun", 64'(und), 0);
    rst_n = 1;

    // R1 bit period
    @(posedge sck); t0 = $time;
    @(posedge sck); t1 = $time;
    check("R1 sck period", 64'((t1 - t0) / CLK_P), 64'(2 * HALF));

    // R8 starvation frame
    grab(f, u, -1, 0, 0, 0);
    check("R8 silent frame", f, 64'd0);
    check("R8 underrun high", 64'(u), 1);

    // R4 R5 all widths, both orders
    for (int w = 0; w < 4; w++) begin
      for (int b = 0; b < 2; b++) begin
        width = 2'(w); lsb = b[0]; mono = 0;
        l = 24'h9B37E1 ^ (24'h135791 * w) ^ (b ? 24'hF0F0F0 : 0);
        r = 24'h4CD286 ^ (24'h2468AC * w);
        push(l, r);
        grab(f, u, -1, 2'(w), b[0], 0);
        check($sformatf("R4 R5 frame w=%0d lsb=%0d", wbits(2'(w)), b), f,
              frame(l, r, wbits(2'(w)), b[0]));
        check("R8 underrun low with sample", 64'(u), 0);
      end
    end

    // R6 mono duplication, right input ignored
    width = 2'd1; lsb = 0; mono = 1;
    push(24'hC0FFEE, 24'h123456);
    grab(f, u, -1, 2'd1, 0, 1);
    check("R6 mono frame", f, frame(24'hC0FFEE, 24'hC0FFEE, 18, 0));

    // R9 mid-frame configuration change
    width = 2'd3; lsb = 0; mono = 0;
    push(24'hA1B2C3, 24'h5D6E7F);
    grab(f, u, 8, 2'd0, 1, 1);
    check("R9 frame keeps old config", f, frame(24'hA1B2C3, 24'h5D6E7F, 24, 0));
    push(24'h8E1F07, 24'h33CC55);
    grab(f, u, -1, 2'd0, 1, 1);
    check("R9 next frame uses new config", f, frame(24'h8E1F07, 24'h8E1F07, 16, 1));

    // R8 underrun again after samples stop
    grab(f, u, -1, 2'd0, 1, 1);
    check("R8 zeros after starvation", f, 64'd0);
    check("R8 underrun raised again", 64'(u), 1);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule